// File: doc/BRIEF.md
# Double-Banked Event Item Store

This block sits between a producer of event items and a 32-bit readout bus. Each item is a pair of 32-bit words, and the producer presents both words together in one cycle. The block writes the pair into whichever of two equal banks is currently filling. A bank is handed to the reader in two cases: it reaches its item capacity, or a periodic flush tick arrives while it holds at least one item. While the reader drains that bank one word per cycle, new items keep landing in the other bank.

The reader sees a ready flag, the number of valid words, and which bank it is reading. It fetches words by address with a one-cycle read latency. A done strobe from the reader frees the bank. When the filling bank is full and the other bank has not been released, the block raises pause toward the producer and refuses items. Pause drops again once the reader frees its bank. Because both words of an item are stored in the same cycle, a bank never holds a half-written item.

Top module: `item_pingpong_store`

## Requirements
- R1: After reset, pause is 0, rd_ready is 0, rd_count is 0 and rd_bank is 1. The first bank to be filled is bank 0.
- R2: An item is accepted in a cycle where in_valid is 1 and pause is 0. Item k of a bank (counting from 0) puts in_word0 at word address 2k and in_word1 at word address 2k+1.
- R3: When the accepted item brings the filling bank to BANK_WORDS/2 items and the other bank is free, the banks swap. From the next cycle rd_ready is 1 and rd_count equals BANK_WORDS.
- R4: When flush_tick is 1, the filling bank holds at least one item (including one accepted in that same cycle) and the other bank is free, the banks swap. From the next cycle rd_count is twice the item count.
- R5: A flush_tick while the filling bank is empty, with no item accepted in that cycle, has no effect: rd_ready stays 0 and no swap happens.
- R6: When the filling bank is full and the other bank is still held by the reader, pause is 1 and in_valid is ignored. No refused item ever appears in stored data.
- R7: rd_done while rd_ready is 1 frees the bank, and rd_ready is 0 from the next cycle. If the filling bank is full in that same cycle, the swap happens at once: rd_ready stays 1 with the new count, and pause is 0 from the next cycle.
- R8: With rd_en at 1, rd_data holds, one cycle later, the word at rd_addr of the bank named by rd_bank.
- R9: rd_done while rd_ready is 0 has no effect.
- R10: A flush_tick that arrives while the reader still holds the other bank is dropped. The held bank's count is unchanged, and releasing the bank later does not swap unless the filling bank is full.
- R11: rd_bank names the bank most recently handed to the reader. It toggles at every swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Item offered by the producer |
| in_word0 | input | DW | First word of the item |
| in_word1 | input | DW | Second word of the item |
| flush_tick | input | 1 | Periodic request to hand over a partly filled bank |
| pause | output | 1 | Items refused; producer must hold off |
| rd_ready | output | 1 | A bank is available to the reader |
| rd_count | output | $clog2(BANK_WORDS)+1 | Valid words in the bank being read |
| rd_bank | output | 1 | Index of the bank being read |
| rd_en | input | 1 | Read request |
| rd_addr | input | $clog2(BANK_WORDS) | Word address within the bank being read |
| rd_data | output | DW | Word read, one cycle after rd_en |
| rd_done | input | 1 | Reader releases its bank |

## Verification
The collisions that matter are a swap and a release in the same cycle, and a swap and a flush in the same cycle. In the first, rd_done lands while the filling bank is full. In the second, a flush tick coincides with the accept of the item that fills the bank. Both are set up directly: the bank is filled until pause rises and the release is then issued, and the final item is presented together with a flush. The random phase then throws ticks, items, reads and releases at arbitrary moments. Every cycle, a bench model that tracks both banks' contents and ownership judges pause, rd_ready, rd_count, rd_bank and each word read back.

// File: rtl/ppstore_pkg.sv
package ppstore_pkg;
  // number of 32-bit words occupied by a number of two-word items
  function automatic int unsigned words_of(input int unsigned items);
    return items * 2;
  endfunction

  // item count after a cycle that may have accepted one item
  function automatic int unsigned fill_after(input int unsigned fill, input logic took);
    return fill + (took ? 1 : 0);
  endfunction
endpackage

// File: rtl/ppstore_bank.sv
module ppstore_bank #(
  parameter int DW    = 32,
  parameter int ITEMS = 512,
  localparam int IW   = $clog2(ITEMS),
  localparam int AW   = IW + 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] wslot,
  input  logic [DW-1:0] wd0,
  input  logic [DW-1:0] wd1,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  // two lanes so both words of an item land in one cycle
  logic [DW-1:0] lane_even [ITEMS];
  logic [DW-1:0] lane_odd  [ITEMS];

  always_ff @(posedge clk) begin
    if (we) begin
      lane_even[wslot] <= wd0;
      lane_odd[wslot]  <= wd1;
    end
  end

  always_ff @(posedge clk) begin
    if (re) q <= raddr[0] ? lane_odd[raddr[AW-1:1]] : lane_even[raddr[AW-1:1]];
  end
endmodule

// File: rtl/ppstore_ctrl.sv
module ppstore_ctrl
  import ppstore_pkg::*;
#(
  parameter int ITEMS = 512,
  localparam int IW   = $clog2(ITEMS),
  localparam int CW   = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          flush_tick,
  input  logic          rd_done,
  output logic          acc,
  output logic          wsel,
  output logic [IW-1:0] wslot,
  output logic          pause,
  output logic          offered,
  output logic [CW-1:0] ocnt
);
  logic [CW-1:0] fill, fill_nx;
  logic          other_free, swap, hit_full, hit_flush;

  assign pause      = (fill == CW'(ITEMS));
  assign acc        = in_valid && !pause;
  assign wslot      = fill[IW-1:0];
  assign fill_nx    = CW'(fill_after(int'(fill), acc));
  assign other_free = !offered || rd_done;
  assign hit_full   = (fill_nx == CW'(ITEMS));
  assign hit_flush  = flush_tick && (fill_nx != '0);
  assign swap       = other_free && (hit_full || hit_flush);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill    <= '0;
      wsel    <= 1'b0;
      offered <= 1'b0;
      ocnt    <= '0;
    end else if (swap) begin
      fill    <= '0;
      wsel    <= ~wsel;
      offered <= 1'b1;
      ocnt    <= fill_nx;
    end else begin
      fill <= fill_nx;
      if (rd_done) offered <= 1'b0;
    end
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(ITEMS)); // R6
  AST_PAUSE_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    pause && in_valid |=> (fill == CW'(ITEMS)) || (fill == '0)); // R6
  AST_OFFER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    offered && !rd_done |=> offered && $stable(ocnt) && $stable(wsel)); // R10
  AST_OFFER_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    offered |-> ocnt != '0); // R4
  AST_DONE_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    pause && offered && rd_done |=> !pause && offered && (ocnt == CW'(ITEMS))); // R7
  AST_EMPTY_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    flush_tick && !in_valid && (fill == '0) |=> (fill == '0) && $stable(wsel)); // R5
  AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !offered && rd_done && !in_valid && !flush_tick |=> !offered); // R9
endmodule

// File: rtl/item_pingpong_store.sv
module item_pingpong_store
  import ppstore_pkg::*;
#(
  parameter int DW         = 32,
  parameter int BANK_WORDS = 1024,
  localparam int ITEMS     = BANK_WORDS / 2,
  localparam int IW        = $clog2(ITEMS),
  localparam int CW        = IW + 1,
  localparam int AW        = $clog2(BANK_WORDS),
  localparam int WCW       = AW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [DW-1:0]  in_word0,
  input  logic [DW-1:0]  in_word1,
  input  logic           flush_tick,
  output logic           pause,
  output logic           rd_ready,
  output logic [WCW-1:0] rd_count,
  output logic           rd_bank,
  input  logic           rd_en,
  input  logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data,
  input  logic           rd_done
);
  logic          acc, wsel, offered, rsel;
  logic [IW-1:0] wslot;
  logic [CW-1:0] ocnt;
  logic [DW-1:0] q [2];

  ppstore_ctrl #(.ITEMS(ITEMS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .flush_tick(flush_tick),
    .rd_done(rd_done), .acc(acc), .wsel(wsel), .wslot(wslot), .pause(pause),
    .offered(offered), .ocnt(ocnt)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    ppstore_bank #(.DW(DW), .ITEMS(ITEMS)) u_bank (
      .clk(clk),
      .we(acc && (wsel == 1'(b))),
      .wslot(wslot), .wd0(in_word0), .wd1(in_word1),
      .re(rd_en && (wsel != 1'(b))),
      .raddr(rd_addr),
      .q(q[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rsel <= 1'b1;
    else if (rd_en) rsel <= ~wsel;
  end

  assign rd_ready = offered;
  assign rd_bank  = ~wsel;
  assign rd_count = offered ? WCW'(words_of(int'(ocnt))) : '0;
  assign rd_data  = q[rsel];

  AST_COUNT_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> (rd_count[0] == 1'b0) && (rd_count <= WCW'(BANK_WORDS))); // R2
  AST_BANK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ready |=> rd_ready ? (rd_bank != $past(rd_bank)) : $stable(rd_bank)); // R11
endmodule

// File: tb/item_pingpong_store_test.sv
`timescale 1ns/1ps
module item_pingpong_store_test;
  localparam int BW = 1024;
  localparam int NI = BW / 2;

  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, flush_tick = 0, rd_en = 0, rd_done = 0;
  logic [31:0] in_word0 = 0, in_word1 = 0;
  logic [9:0]  rd_addr = 0;
  logic        pause, rd_ready, rd_bank;
  logic [10:0] rd_count;
  logic [31:0] rd_data;

  item_pingpong_store #(.DW(32), .BANK_WORDS(BW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word0(in_word0),
    .in_word1(in_word1), .flush_tick(flush_tick), .pause(pause),
    .rd_ready(rd_ready), .rd_count(rd_count), .rd_bank(rd_bank),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_done(rd_done)
  );

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  // bench model of both banks
  logic [31:0] mact [BW];
  logic [31:0] moff [BW];
  int  mfill = 0, mocnt = 0;
  bit  mheld = 0, mwsel = 0;

  function automatic int words(input int items); return items + items; endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one cycle from a negedge, update the model at the edge, compare at next negedge
  task automatic step(input bit v, input bit fl, input bit ren, input int ra, input bit dn);
    bit took, sw;
    int nf;
    logic [31:0] w0, w1, expd;
    w0 = $urandom; w1 = $urandom;
    in_valid = v; in_word0 = w0; in_word1 = w1; flush_tick = fl;
    rd_en = ren; rd_addr = 10'(ra); rd_done = dn;
    @(posedge clk);
    took = v && (mfill != NI);
    nf = mfill + (took ? 1 : 0);
    if (took) begin mact[2*mfill] = w0; mact[2*mfill+1] = w1; end
    expd = moff[ra];
    sw = (!mheld || dn) && (nf == NI || (fl && nf != 0));
    if (sw) begin
      for (int i = 0; i < words(nf); i++) moff[i] = mact[i];
      mheld = 1; mocnt = nf; mwsel = ~mwsel; mfill = 0;
    end else begin
      mfill = nf;
      if (dn) mheld = 0;
    end
    @(negedge clk);
    in_valid = 0; flush_tick = 0; rd_en = 0; rd_done = 0;
    check(pause == (mfill == NI), "R6 pause", pause, mfill == NI);
    check(rd_ready == mheld, "R7 rd_ready", rd_ready, mheld);
    check(rd_count == (mheld ? words(mocnt) : 0), "R4 rd_count", rd_count, mheld ? words(mocnt) : 0);
    check(rd_bank == ~mwsel, "R11 rd_bank", rd_bank, ~mwsel);
    if (ren) check(rd_data == expd, "R2 R8 rd_data", rd_data, expd);
  endtask

  task automatic push_until(input int target);
    while (mfill < target) step($urandom_range(0, 9) < 7, 0, 0, 0, 0);
  endtask

  task automatic drain_all();
    for (int i = 0; i < words(mocnt); i++) step(0, 0, 1, i, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check(pause == 0 && rd_ready == 0 && rd_count == 0, "R1 reset outputs", {pause, rd_ready, rd_count}, 0);
    check(rd_bank == 1, "R1 reset bank", rd_bank, 1);

    // R9 release with nothing held
    step(0, 0, 0, 0, 1);
    check(rd_ready == 0, "R9 idle done", rd_ready, 0);

    // R4 flush of three items, last one accepted with the tick
    step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0); step(1, 1, 0, 0, 0);
    check(rd_ready && rd_count == 6 && rd_bank == 0, "R4 flush swap", rd_count, 6);
    drain_all();
    step(0, 0, 0, 0, 1);
    check(rd_ready == 0, "R7 release", rd_ready, 0);

    // R5 flush on empty bank
    step(0, 1, 0, 0, 0);
    check(rd_ready == 0 && rd_count == 0, "R5 empty flush", rd_ready, 0);

    // R3 full swap, final item coinciding with a flush
    push_until(NI - 1);
    step(1, 1, 0, 0, 0);
    check(rd_ready && rd_count == BW && rd_bank == 1, "R3 full swap", rd_count, BW);

    // R10 flush while reader holds a bank
    push_until(10);
    step(0, 1, 0, 0, 0);
    check(rd_count == BW && rd_bank == 1, "R10 flush dropped", rd_count, BW);
    step(0, 0, 5, 5, 1);
    check(rd_ready == 0, "R10 no swap on release", rd_ready, 0);
    step(0, 1, 0, 0, 0);
    check(rd_count == 20 && rd_bank == 0, "R10 later flush", rd_count, 20);

    // R6 fill the other bank while held, then try more items
    push_until(NI);
    check(pause == 1, "R6 pause raised", pause, 1);
    for (int i = 0; i < 8; i++) step(1, i[0], 1, i, 0);
    check(pause == 1 && rd_count == 20, "R6 refused", rd_count, 20);

    // R7 release collides with a pending full swap
    step(0, 0, 0, 0, 1);
    check(rd_ready && rd_count == BW && pause == 0, "R7 release plus swap", rd_count, BW);
    drain_all();
    step(0, 0, 0, 0, 1);

    // random phase
    for (int c = 0; c < 6000; c++) begin
      bit v, fl, ren, dn;
      int ra;
      v  = $urandom_range(0, 9) < 6;
      fl = $urandom_range(0, 63) == 0;
      ren = mheld && ($urandom_range(0, 1) == 1);
      ra = (mocnt > 0) ? $urandom_range(0, words(mocnt) - 1) : 0;
      dn = $urandom_range(0, 99) < 2;
      step(v, fl, ren, ra, dn);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule